// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor that completes one instruction in each clock period. It supports a compact load/store instruction subset: unsigned add, unsigned subtract, OR with immediate, word load, word store, branch when equal, and absolute jump. The core contains the program counter, a 32 x 32-bit register file, an immediate extender, an ALU, and a two-level decoder. The main decoder produces named steering controls. A small local decoder turns the function field into an ALU operation.

All state changes on the falling clock edge. This covers the program counter, the register file, and both word memories. The instruction memory and data memory are internal word arrays. Their reads are combinational and their writes are clocked. Before the core runs, both arrays are filled through a word-wide load port. The load port has no ready signal: every word presented with `ld_valid` high is written at the next falling edge, so there is no back-pressure.

A debug port shows two things. It shows the address of the instruction now executing. It also shows the register write that this instruction will commit at the coming falling edge.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous, active high and sampled on the falling edge, where it sets the PC to 0. While reset is high, no register write and no data-memory store takes place, and `dbg_wr_en` is 0.
- R2: Every instruction is 32 bits, fetched from the word at PC[7:2]. Instructions that are not a branch or jump set the next PC to PC+4.
- R3: Opcode 0x00 selects the R format {op[31:26], rs[25:21], rt[20:16], rd[15:11], sh[10:6], fn[5:0]}. Function 0x21 writes rs+rt to rd, and function 0x23 writes rs-rt to rd. Both wrap modulo 2^32.
- R4: Opcode 0x0D writes rs OR zero-extended imm[15:0] to rt.
- R5: Opcode 0x23 loads into rt the data word at byte address rs + sign-extended imm. Opcode 0x2B stores rt to that same address and writes no register.
- R6: Opcode 0x04 compares rs and rt by subtraction. When they are equal, the next PC is PC+4+(sign-extended imm x 4). Otherwise the next PC is PC+4.
- R7: Opcode 0x02 sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R8: Register 0 always reads as 0. A write aimed at it is discarded and does not raise `dbg_wr_en`.
- R9: Any other opcode, and an R-format instruction with a function code other than 0x21 or 0x23, writes nothing and only advances the PC by 4.
- R10: With `ld_valid` high, `ld_data` is written at the falling edge to word `ld_addr`. The target is data memory when `ld_dmem` is 1 and instruction memory when it is 0.
- R11: `dbg_pc` shows the current PC. `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show the register write that the current instruction commits at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load-port word strobe |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | 6 | Load-port word index |
| ld_data | input | 32 | Load-port data word |
| dbg_pc | output | 32 | Address of the executing instruction |
| dbg_wr_en | output | 1 | A register write commits at the next falling edge |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
Each instruction's results are visible combinationally during the high phase that precedes the falling edge at which it commits. The PC it produces appears in `dbg_pc` one full period later. The bench therefore drives and samples only around rising edges: it checks `dbg_pc` and the debug write fields 1 ns after a rising edge, and the falling edge that follows executes that instruction. The effect of a store is checked later, when a following load returns the stored word on the write port. The effect of reset is checked at the first rising edge after the falling edge that sampled it.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JMP   = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADDU   = 6'h21;
  localparam logic [5:0] FN_SUBU   = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_ctr_e;
  typedef enum logic [1:0] {AOP_RTYPE, AOP_OR, AOP_ADD, AOP_SUB} alu_op_e;
  typedef enum logic [1:0] {NPC_SEQ, NPC_BR, NPC_JMP} npc_sel_e;

  typedef struct packed {
    logic     reg_dst;
    logic     alu_src;
    logic     mem_to_reg;
    logic     reg_wr;
    logic     mem_wr;
    logic     ext_sign;
    npc_sel_e npc_sel;
    alu_op_e  alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_core_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output ctrl_t      ctl,
  output alu_ctr_e   alu_ctr,
  output logic       fn_ok
);
  // main decoder: steering controls from the opcode
  always_comb begin
    ctl         = '0;
    ctl.npc_sel = NPC_SEQ;
    ctl.alu_op  = AOP_ADD;
    case (opc)
      OPC_RTYPE: begin
        ctl.reg_dst = 1'b1;
        ctl.reg_wr  = 1'b1;
        ctl.alu_op  = AOP_RTYPE;
      end
      OPC_ORI: begin
        ctl.alu_src = 1'b1;
        ctl.reg_wr  = 1'b1;
        ctl.alu_op  = AOP_OR;
      end
      OPC_LW: begin
        ctl.alu_src    = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_wr     = 1'b1;
        ctl.ext_sign   = 1'b1;
      end
      OPC_SW: begin
        ctl.alu_src  = 1'b1;
        ctl.mem_wr   = 1'b1;
        ctl.ext_sign = 1'b1;
      end
      OPC_BEQ: begin
        ctl.npc_sel = NPC_BR;
        ctl.alu_op  = AOP_SUB;
      end
      OPC_JMP: ctl.npc_sel = NPC_JMP;
      default: ;
    endcase
  end

  // local decoder: ALU operation from the ALU class and the function field
  always_comb begin
    alu_ctr = ALU_ADD;
    fn_ok   = 1'b1;
    case (ctl.alu_op)
      AOP_RTYPE: begin
        case (fn)
          FN_ADDU: alu_ctr = ALU_ADD;
          FN_SUBU: alu_ctr = ALU_SUB;
          default: fn_ok = 1'b0;
        endcase
      end
      AOP_OR:  alu_ctr = ALU_OR;
      AOP_SUB: alu_ctr = ALU_SUB;
      default: alu_ctr = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctr_e     ctr,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (ctr)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [RAW-1:0] ra,
  input  logic [RAW-1:0] rb,
  output logic [W-1:0]   da,
  output logic [W-1:0]   db
);
  logic [W-1:0] regs [NREG];

  always_ff @(negedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign da = (ra == '0) ? '0 : regs[ra];
  assign db = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int AW = 6,
  parameter int W  = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(negedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wr_en,
  output logic [4:0]        dbg_wr_addr,
  output logic [XLEN-1:0]   dbg_wr_data
);
  localparam int IDX_HI = MEM_AW + 1;

  logic [XLEN-1:0] pc_q, pc_next, pc_inc, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, imm_ext, bus_a, bus_b, alu_b, alu_y, dm_rdata, wb_data;
  logic [4:0]      f_rs, f_rt, f_rd, wr_addr;
  logic [15:0]     f_imm;
  logic [XLEN-1:0] imm_sext;
  ctrl_t           ctl;
  alu_ctr_e        alu_ctr;
  logic            fn_ok, alu_zero, rf_we, dm_core_we;
  logic            dm_we;
  logic [MEM_AW-1:0] dm_waddr;
  logic [XLEN-1:0]   dm_wdata;

  // instruction memory
  sc_wordmem #(.AW(MEM_AW), .W(XLEN)) imem_i (
    .clk   (clk),
    .we    (ld_valid & ~ld_dmem),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[IDX_HI:2]),
    .rdata (instr)
  );

  // field split
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  sc_ctrl ctrl_i (
    .opc     (instr[31:26]),
    .fn      (instr[5:0]),
    .ctl     (ctl),
    .alu_ctr (alu_ctr),
    .fn_ok   (fn_ok)
  );

  // extender
  assign imm_sext = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign imm_ext  = ctl.ext_sign ? imm_sext : {{(XLEN-16){1'b0}}, f_imm};

  // register file
  assign wr_addr = ctl.reg_dst ? f_rd : f_rt;
  assign rf_we   = ctl.reg_wr & fn_ok & ~rst;

  sc_regfile #(.NREG(32), .W(XLEN)) rf_i (
    .clk   (clk),
    .we    (rf_we),
    .waddr (wr_addr),
    .wdata (wb_data),
    .ra    (f_rs),
    .rb    (f_rt),
    .da    (bus_a),
    .db    (bus_b)
  );

  // execute
  assign alu_b = ctl.alu_src ? imm_ext : bus_b;

  sc_alu #(.W(XLEN)) alu_i (
    .a    (bus_a),
    .b    (alu_b),
    .ctr  (alu_ctr),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: the load port has priority over a core store
  assign dm_core_we = ctl.mem_wr & ~rst;
  assign dm_we      = (ld_valid & ld_dmem) | dm_core_we;
  assign dm_waddr   = (ld_valid & ld_dmem) ? ld_addr : alu_y[IDX_HI:2];
  assign dm_wdata   = (ld_valid & ld_dmem) ? ld_data : bus_b;

  sc_wordmem #(.AW(MEM_AW), .W(XLEN)) dmem_i (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[IDX_HI:2]),
    .rdata (dm_rdata)
  );

  assign wb_data = ctl.mem_to_reg ? dm_rdata : alu_y;

  // next address
  assign pc_inc  = pc_q + 32'd4;
  assign br_tgt  = pc_inc + {imm_sext[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_inc[XLEN-1:28], instr[25:0], 2'b00};

  always_comb begin
    case (ctl.npc_sel)
      NPC_BR:  pc_next = alu_zero ? br_tgt : pc_inc;
      NPC_JMP: pc_next = jmp_tgt;
      default: pc_next = pc_inc;
    endcase
  end

  always_ff @(negedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // debug view
  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = rf_we & (wr_addr != 5'd0);
  assign dbg_wr_addr = wr_addr;
  assign dbg_wr_data = wb_data;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], alu_y[1:0], alu_y[XLEN-1:IDX_HI+1], instr[10:6]};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wr_en
);
  logic armed = 1'b0;
  always @(negedge clk) armed <= 1'b1;

  AST_RESET_PC: assert property (@(negedge clk) disable iff (rst)
    (armed && $fell(rst)) |-> (pc == 32'd0)) else $error("reset pc"); // R1

  always @(negedge clk) begin
    if (rst) begin
      AST_NO_WR_IN_RESET: assert (!wr_en) else $error("write in reset"); // R1
    end
  end

  AST_PC_ALIGNED: assert property (@(negedge clk) disable iff (rst)
    armed |-> (pc[1:0] == 2'b00)) else $error("pc align"); // R2

  AST_SEQ_STEP: assert property (@(negedge clk) disable iff (rst)
    (armed && !$past(rst) && ($past(instr[31:26]) != 6'h04) && ($past(instr[31:26]) != 6'h02))
      |-> (pc == $past(pc) + 32'd4)) else $error("seq step"); // R2

  AST_JMP_TARGET: assert property (@(negedge clk) disable iff (rst)
    (armed && !$past(rst) && ($past(instr[31:26]) == 6'h02))
      |-> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00})) else $error("jump"); // R7
endmodule

bind sc_core sc_core_chk chk_i (
  .clk   (clk),
  .rst   (rst),
  .pc    (pc_q),
  .instr (instr),
  .wr_en (dbg_wr_en)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic load_word(input bit to_dmem, input int idx, input logic [31:0] w);
    @(posedge clk);
    ld_valid = 1'b1; ld_dmem = to_dmem; ld_addr = idx[5:0]; ld_data = w;
  endtask

  // check at 1 ns after the current rising edge, then move to the next one
  task automatic step(input logic [31:0] pc, input bit we, input logic [4:0] wa,
                      input logic [31:0] wd, input string req);
    #1;
    checks++;
    if (dbg_pc !== pc || dbg_wr_en !== we ||
        (we && (dbg_wr_addr !== wa || dbg_wr_data !== wd))) begin
      errors++;
      $display("FAIL %s: pc=%h we=%b wa=%0d wd=%h expected pc=%h we=%b wa=%0d wd=%h",
               req, dbg_pc, dbg_wr_en, dbg_wr_addr, dbg_wr_data, pc, we, wa, wd);
    end
    @(posedge clk);
  endtask

  task automatic t_load_program;
    logic [31:0] bad;
    bad = enc_i(6'h0D, 5'd0, 5'd9, 16'h0BAD);
    load_word(0, 0,  enc_i(6'h0D, 5'd0, 5'd1, 16'h1234));
    load_word(0, 1,  enc_i(6'h0D, 5'd0, 5'd2, 16'hFFFF));
    load_word(0, 2,  enc_r(5'd1, 5'd2, 5'd3, 6'h21));
    load_word(0, 3,  enc_r(5'd1, 5'd2, 5'd4, 6'h23));
    load_word(0, 4,  enc_i(6'h2B, 5'd0, 5'd3, 16'd8));
    load_word(0, 5,  enc_i(6'h23, 5'd0, 5'd5, 16'd8));
    load_word(0, 6,  enc_i(6'h0D, 5'd0, 5'd7, 16'd24));
    load_word(0, 7,  enc_i(6'h23, 5'd7, 5'd6, 16'hFFFC));
    load_word(0, 8,  enc_i(6'h0D, 5'd1, 5'd0, 16'd5));
    load_word(0, 9,  enc_r(5'd0, 5'd0, 5'd8, 6'h21));
    load_word(0, 10, enc_i(6'h04, 5'd5, 5'd3, 16'd2));
    load_word(0, 11, bad);
    load_word(0, 12, bad);
    load_word(0, 13, enc_i(6'h04, 5'd5, 5'd6, 16'd5));
    load_word(0, 14, 32'hFC00_0000);
    load_word(0, 15, enc_r(5'd1, 5'd2, 5'd12, 6'h24));
    load_word(0, 16, {6'h02, 26'd19});
    load_word(0, 17, bad);
    load_word(0, 18, bad);
    load_word(0, 19, enc_r(5'd4, 5'd6, 5'd13, 6'h21));
    load_word(0, 20, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));
    load_word(1, 5,  32'hCAFE_0001);
    @(posedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(posedge clk);
    step(32'd0, 1'b0, 5'd0, 32'd0, "R1 reset state");
    rst = 1'b0;
  endtask

  task automatic t_alu;
    step(32'd0,  1'b1, 5'd1, 32'h0000_1234, "R4 ori");
    step(32'd4,  1'b1, 5'd2, 32'h0000_FFFF, "R4 zero extend");
    step(32'd8,  1'b1, 5'd3, 32'h0001_1233, "R3 addu");
    step(32'd12, 1'b1, 5'd4, 32'hFFFF_1235, "R3 subu");
  endtask

  task automatic t_mem;
    step(32'd16, 1'b0, 5'd0, 32'd0, "R5 sw no write");
    step(32'd20, 1'b1, 5'd5, 32'h0001_1233, "R5 lw after sw");
    step(32'd24, 1'b1, 5'd7, 32'h0000_0018, "R2 R4 ori base");
    step(32'd28, 1'b1, 5'd6, 32'hCAFE_0001, "R5 R10 lw negative offset");
  endtask

  task automatic t_zero_reg;
    step(32'd32, 1'b0, 5'd0, 32'd0, "R8 write to r0");
    step(32'd36, 1'b1, 5'd8, 32'd0, "R8 r0 reads zero");
  endtask

  task automatic t_branch;
    step(32'd40, 1'b0, 5'd0, 32'd0, "R6 beq taken");
    step(32'd52, 1'b0, 5'd0, 32'd0, "R6 beq not taken");
  endtask

  task automatic t_noop;
    step(32'd56, 1'b0, 5'd0, 32'd0, "R9 unknown opcode");
    step(32'd60, 1'b0, 5'd0, 32'd0, "R9 unknown function");
  endtask

  task automatic t_jump;
    step(32'd64, 1'b0, 5'd0, 32'd0, "R7 jump");
    step(32'd76, 1'b1, 5'd13, 32'hCAFD_1236, "R7 R3 landing and wrap");
  endtask

  task automatic t_loop;
    step(32'd80, 1'b0, 5'd0, 32'd0, "R6 backward branch");
    step(32'd80, 1'b0, 5'd0, 32'd0, "R6 R11 self loop");
  endtask

  task automatic t_midrun_reset;
    rst = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (dbg_pc !== 32'd0 || dbg_wr_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 mid-run reset: pc=%h we=%b expected pc=0 we=0", dbg_pc, dbg_wr_en);
    end
    rst = 1'b0;
    step(32'd0, 1'b1, 5'd1, 32'h0000_1234, "R1 R11 restart");
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_load_program();
    t_reset();
    t_alu();
    t_mem();
    t_zero_reg();
    t_branch();
    t_noop();
    t_jump();
    t_loop();
    t_midrun_reset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule